// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a parallel NOR flash array. The array holds 16-bit words and is addressed by 19-bit word addresses. The host issues bus write cycles framed by a write-enable strobe and a chip-enable strobe, both active low. The decoder takes one command byte per cycle from the low byte of the data bus. It follows one-cycle and two-cycle command sequences and decides whether host reads return array data, identifier codes or the status byte.

Accepted word writes, block erases and lock-bit operations leave the block as a one-cycle start pulse. The pulse carries an operation code, an address and a data word, and goes to an external write machine. The write machine reports back on a single busy line. Suspend and resume requests go out as pulses of their own.

Protection has three layers. Each block has its own lock bit. A one-way permanent lock bit sits above them. A high-voltage reset indication input can override a block lock. A rejected operation is reported in the status byte, and no operation is started for it.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (code 0), the status byte is 0x80, all block locks and the permanent lock are clear, and wsm_start, wsm_suspend and wsm_resume are low.
- R2: One bus cycle is enough for four commands. FFh sets read mode array (0), 90h sets identifier (1) and 70h sets status (2). 50h clears status bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R3: A bus cycle is recognised only when both strobes have been low together and one of them then returns high. The address and data present at that release are the ones used. A strobe that goes low while the other stays high has no effect.
- R4: A first cycle of 40h or 10h followed by any second cycle gives one wsm_start pulse. The pulse carries op code 1 (write) and the second cycle's address and full 16-bit data.
- R5: A first cycle of 20h followed by D0h gives one wsm_start pulse with op code 2 (erase) and the second cycle's address. Any other second byte starts nothing, sets status bits 5 and 4 and returns the decoder to idle.
- R6: A byte outside the defined set, received in idle while no operation is busy or suspended, starts nothing. It sets status bits 5 and 4 and switches the read mode to status.
- R7: A first cycle of 60h is followed by one of three bytes. 01h sets the lock of the block in address bits 18:15 (op 3). F1h sets the permanent lock (op 4). D0h clears all block locks (op 5). Each of these needs the high-voltage input. Without it nothing starts and status bit 3 is set, together with bit 4 (for 01h or F1h) or bit 5 (for D0h).
- R8: Once the permanent lock is set, no command clears it. While it is set, 60h/01h and 60h/D0h leave the block locks unchanged and set status bit 1, together with bit 4 or bit 5 respectively.
- R9: An erase or word write addressed to a locked block, with the high-voltage input low, starts nothing and sets status bit 1 plus bit 5 (erase) or bit 4 (write). With the high-voltage input high it proceeds.
- R10: Status bit 7 reads 0 whenever wsm_busy is high and 1 otherwise, in the same cycle.
- R11: While busy and not suspended, B0h pulses wsm_suspend and sets status bit 6. While suspended, D0h pulses wsm_resume and clears bit 6. While busy or suspended, setup commands and undefined bytes are ignored.
- R12: Every setup cycle, start, rejection, suspend or resume leaves the read mode at status, and it stays there until a FFh or 90h cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Write-enable strobe, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| addr | input | 19 | Word address of the bus cycle |
| din | input | 16 | Data of the bus cycle; the command byte is bits 7:0 |
| hv_reset | input | 1 | High-voltage reset indication, unlocks protected operations |
| wsm_busy | input | 1 | External write machine busy |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |
| status | output | 8 | Status byte: 7 ready, 6 suspended, 5 erase/clear error, 4 write/set error, 3 high-voltage missing, 1 lock violation |
| wsm_start | output | 1 | One-cycle start pulse |
| wsm_op | output | 3 | Operation: 1 write, 2 erase, 3 set block lock, 4 set permanent lock, 5 clear block locks |
| wsm_addr | output | 19 | Address of the started operation |
| wsm_data | output | 16 | Data of the started operation |
| wsm_suspend | output | 1 | One-cycle suspend request |
| wsm_resume | output | 1 | One-cycle resume request |
| block_locks | output | 16 | Lock bit of each block |
| perm_lock | output | 1 | Permanent lock bit |

## Verification
The bench targets the following corner cases.

- **Locked blocks.** A design that checks a lock against the wrong address bits, or ignores the high-voltage input, starts writes to a locked block or refuses legal ones.
- **Lock changes with the permanent lock set.** A decoder that lets lock changes through once the permanent lock is set shows block locks changing afterwards.
- **Setup followed by a wrong second byte.** A decoder that stays in setup after such a cycle turns a later stray D0h into an erase.
- **Single-strobe cycles.** A design that samples one strobe alone reacts to writes with chip-enable high.
- **Commands during busy or suspend.** A decoder that accepts setup commands while busy or suspended would start a write or erase from the following cycle instead of ignoring it. The bench also checks that the ready bit follows the busy line.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_LSET  = 3'd3,
    OP_LPERM = 3'd4,
    OP_LCLR  = 3'd5
  } wop_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ERASE,
    SQ_WRITE,
    SQ_LOCK
  } seq_t;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_IDENT = 8'h90;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_WRITE_A  = 8'h40;
  localparam logic [7:0] C_WRITE_B  = 8'h10;
  localparam logic [7:0] C_LOCKSET  = 8'h60;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_LK_BLK   = 8'h01;
  localparam logic [7:0] C_LK_PERM  = 8'hF1;

  // error flag vector order: {erase/clear, write/set, volt, lock}
  localparam int EB_ERASE = 3;
  localparam int EB_WRITE = 2;
  localparam int EB_VOLT  = 1;
  localparam int EB_LOCK  = 0;

  function automatic logic [7:0] pack_status(input logic busy, input logic susp,
                                             input logic [3:0] err);
    return {~busy, susp, err[EB_ERASE], err[EB_WRITE], err[EB_VOLT], 1'b0,
            err[EB_LOCK], 1'b0};
  endfunction

  function automatic logic is_setup(input logic [7:0] c);
    return (c == C_ERASE) || (c == C_WRITE_A) || (c == C_WRITE_B) || (c == C_LOCKSET);
  endfunction

endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          cyc_evt,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);
  logic act_now;
  logic act_q;

  assign act_now = ~we_n & ~ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_now;
  end

  // a cycle ends when the joint-low window closes, whichever strobe rises first
  assign cyc_evt  = act_q & ~act_now;
  assign cyc_addr = addr;
  assign cyc_data = din;
endmodule

// File: rtl/fcd_lockbank.sv
module fcd_lockbank #(
  parameter int NBLK = 16,
  localparam int BB = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [BB-1:0]   set_idx,
  input  logic            perm_set,
  input  logic            clr_all,
  output logic [NBLK-1:0] locks,
  output logic            perm
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n)                                     locks[i] <= 1'b0;
      else if (clr_all)                               locks[i] <= 1'b0;
      else if (set_en && (set_idx == BB'(i)))         locks[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        perm <= 1'b0;
    else if (perm_set) perm <= 1'b1;
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int NBLK = 16,
  localparam int BB = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_evt,
  input  logic [AW-1:0]   cyc_addr,
  input  logic [DW-1:0]   cyc_data,
  input  logic            hv,
  input  logic            busy,
  input  logic [NBLK-1:0] locks,
  input  logic            perm,
  output logic [1:0]      read_mode,
  output logic [7:0]      status,
  output logic            wsm_start,
  output logic [2:0]      wsm_op,
  output logic [AW-1:0]   wsm_addr,
  output logic [DW-1:0]   wsm_data,
  output logic            wsm_suspend,
  output logic            wsm_resume,
  output logic            lk_set_en,
  output logic [BB-1:0]   lk_idx,
  output logic            lk_perm,
  output logic            lk_clr,
  output logic            cmd_err_evt,
  output logic            lock_rej_evt
);
  function automatic logic [BB-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1 -: BB];
  endfunction

  seq_t   st_q, st_n;
  rmode_t mode_q, mode_n;
  logic [3:0] err_q, err_n;
  logic susp_q, susp_n;
  logic go, sus_p, res_p, quiet, blk_locked;
  wop_t gop;
  logic [7:0] code;

  assign code       = cyc_data[7:0];
  assign quiet      = busy | susp_q;
  assign lk_idx     = blk_of(cyc_addr);
  assign blk_locked = locks[lk_idx] & ~hv;

  always_comb begin
    st_n = st_q; mode_n = mode_q; err_n = err_q; susp_n = susp_q;
    go = 1'b0; gop = OP_NONE; sus_p = 1'b0; res_p = 1'b0;
    lk_set_en = 1'b0; lk_perm = 1'b0; lk_clr = 1'b0;
    cmd_err_evt = 1'b0; lock_rej_evt = 1'b0;
    if (cyc_evt) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (code == C_RD_ARRAY)      mode_n = RM_ARRAY;
          else if (code == C_RD_IDENT) mode_n = RM_IDENT;
          else if (code == C_RD_STAT)  mode_n = RM_STATUS;
          else if (code == C_CLR_STAT) err_n = '0;
          else if (code == C_SUSPEND) begin
            if (busy && !susp_q) begin
              sus_p = 1'b1; susp_n = 1'b1; mode_n = RM_STATUS;
            end
          end else if (code == C_CONFIRM && susp_q) begin
            res_p = 1'b1; susp_n = 1'b0; mode_n = RM_STATUS;
          end else if (!quiet) begin
            mode_n = RM_STATUS;
            if (code == C_ERASE)                               st_n = SQ_ERASE;
            else if (code == C_WRITE_A || code == C_WRITE_B)   st_n = SQ_WRITE;
            else if (code == C_LOCKSET)                        st_n = SQ_LOCK;
            else                                               cmd_err_evt = 1'b1;
          end
        end
        SQ_ERASE: begin
          st_n = SQ_IDLE; mode_n = RM_STATUS;
          if (code != C_CONFIRM) cmd_err_evt = 1'b1;
          else if (blk_locked) begin
            err_n[EB_ERASE] = 1'b1; err_n[EB_LOCK] = 1'b1; lock_rej_evt = 1'b1;
          end else begin
            go = 1'b1; gop = OP_ERASE;
          end
        end
        SQ_WRITE: begin
          st_n = SQ_IDLE; mode_n = RM_STATUS;
          if (blk_locked) begin
            err_n[EB_WRITE] = 1'b1; err_n[EB_LOCK] = 1'b1; lock_rej_evt = 1'b1;
          end else begin
            go = 1'b1; gop = OP_WRITE;
          end
        end
        SQ_LOCK: begin
          st_n = SQ_IDLE; mode_n = RM_STATUS;
          if (code == C_LK_BLK) begin
            if (perm) begin
              err_n[EB_WRITE] = 1'b1; err_n[EB_LOCK] = 1'b1; lock_rej_evt = 1'b1;
            end else if (!hv) begin
              err_n[EB_WRITE] = 1'b1; err_n[EB_VOLT] = 1'b1;
            end else begin
              go = 1'b1; gop = OP_LSET; lk_set_en = 1'b1;
            end
          end else if (code == C_LK_PERM) begin
            if (!hv) begin
              err_n[EB_WRITE] = 1'b1; err_n[EB_VOLT] = 1'b1;
            end else begin
              go = 1'b1; gop = OP_LPERM; lk_perm = 1'b1;
            end
          end else if (code == C_CONFIRM) begin
            if (perm) begin
              err_n[EB_ERASE] = 1'b1; err_n[EB_LOCK] = 1'b1; lock_rej_evt = 1'b1;
            end else if (!hv) begin
              err_n[EB_ERASE] = 1'b1; err_n[EB_VOLT] = 1'b1;
            end else begin
              go = 1'b1; gop = OP_LCLR; lk_clr = 1'b1;
            end
          end else cmd_err_evt = 1'b1;
        end
        default: st_n = SQ_IDLE;
      endcase
      if (cmd_err_evt) begin
        err_n[EB_ERASE] = 1'b1; err_n[EB_WRITE] = 1'b1;
        mode_n = RM_STATUS; st_n = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; mode_q <= RM_ARRAY; err_q <= '0; susp_q <= 1'b0;
      wsm_start <= 1'b0; wsm_op <= OP_NONE; wsm_addr <= '0; wsm_data <= '0;
      wsm_suspend <= 1'b0; wsm_resume <= 1'b0;
    end else begin
      st_q <= st_n; mode_q <= mode_n; err_q <= err_n; susp_q <= susp_n;
      wsm_start <= go; wsm_suspend <= sus_p; wsm_resume <= res_p;
      if (go) begin
        wsm_op <= gop; wsm_addr <= cyc_addr; wsm_data <= cyc_data;
      end
    end
  end

  assign read_mode = mode_q;
  assign status    = pack_status(busy, susp_q, err_q);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int NBLK = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_n,
  input  logic            ce_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  input  logic            hv_reset,
  input  logic            wsm_busy,
  output logic [1:0]      read_mode,
  output logic [7:0]      status,
  output logic            wsm_start,
  output logic [2:0]      wsm_op,
  output logic [AW-1:0]   wsm_addr,
  output logic [DW-1:0]   wsm_data,
  output logic            wsm_suspend,
  output logic            wsm_resume,
  output logic [NBLK-1:0] block_locks,
  output logic            perm_lock
);
  localparam int BB = $clog2(NBLK);

  logic          cyc_evt;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          lk_set_en, lk_perm, lk_clr;
  logic [BB-1:0] lk_idx;
  logic          cmd_err_evt, lock_rej_evt;

  fcd_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .addr(addr), .din(din),
    .cyc_evt(cyc_evt), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  fcd_lockbank #(.NBLK(NBLK)) u_locks (
    .clk(clk), .rst_n(rst_n), .set_en(lk_set_en), .set_idx(lk_idx),
    .perm_set(lk_perm), .clr_all(lk_clr), .locks(block_locks), .perm(perm_lock)
  );

  fcd_seq #(.AW(AW), .DW(DW), .NBLK(NBLK)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_evt(cyc_evt), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .hv(hv_reset), .busy(wsm_busy), .locks(block_locks),
    .perm(perm_lock), .read_mode(read_mode), .status(status),
    .wsm_start(wsm_start), .wsm_op(wsm_op), .wsm_addr(wsm_addr),
    .wsm_data(wsm_data), .wsm_suspend(wsm_suspend), .wsm_resume(wsm_resume),
    .lk_set_en(lk_set_en), .lk_idx(lk_idx), .lk_perm(lk_perm), .lk_clr(lk_clr),
    .cmd_err_evt(cmd_err_evt), .lock_rej_evt(lock_rej_evt)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int AW = 19,
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_evt,
  input logic            cmd_err_evt,
  input logic            lock_rej_evt,
  input logic            hv_reset,
  input logic            wsm_start,
  input logic [2:0]      wsm_op,
  input logic [AW-1:0]   wsm_addr,
  input logic            wsm_suspend,
  input logic            wsm_resume,
  input logic [1:0]      read_mode,
  input logic [7:0]      status,
  input logic [NBLK-1:0] block_locks,
  input logic            perm_lock
);
  localparam int BB = $clog2(NBLK);
  logic [NBLK-1:0] lk_q;
  logic            hv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin lk_q <= '0; hv_q <= 1'b0; end
    else        begin lk_q <= block_locks; hv_q <= hv_reset; end
  end

  p_perm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_lock) |-> perm_lock);

  p_perm_freezes_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_lock) |-> $stable(block_locks));

  p_locked_start_hv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_start && (wsm_op == OP_WRITE || wsm_op == OP_ERASE))
      |-> (!lk_q[wsm_addr[AW-1 -: BB]] || hv_q));

  p_start_status_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |-> read_mode == RM_STATUS);

  p_pulse_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wsm_start, wsm_suspend, wsm_resume}));

  p_cmd_err_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_evt |=> (status[5] && status[4] && read_mode == RM_STATUS && !wsm_start));

  p_err_needs_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(cyc_evt));

  p_lock_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rej_evt |=> (status[1] && !wsm_start));
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_evt(cyc_evt), .cmd_err_evt(cmd_err_evt),
  .lock_rej_evt(lock_rej_evt), .hv_reset(hv_reset), .wsm_start(wsm_start),
  .wsm_op(wsm_op), .wsm_addr(wsm_addr), .wsm_suspend(wsm_suspend),
  .wsm_resume(wsm_resume), .read_mode(read_mode), .status(status),
  .block_locks(block_locks), .perm_lock(perm_lock)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, ce_n = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] din = '0;
  logic hv_reset = 1'b0, wsm_busy = 1'b0;
  logic [1:0] read_mode;
  logic [7:0] status;
  logic wsm_start, wsm_suspend, wsm_resume, perm_lock;
  logic [2:0] wsm_op;
  logic [18:0] wsm_addr;
  logic [15:0] wsm_data;
  logic [15:0] block_locks;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .addr(addr), .din(din),
    .hv_reset(hv_reset), .wsm_busy(wsm_busy), .read_mode(read_mode), .status(status),
    .wsm_start(wsm_start), .wsm_op(wsm_op), .wsm_addr(wsm_addr), .wsm_data(wsm_data),
    .wsm_suspend(wsm_suspend), .wsm_resume(wsm_resume), .block_locks(block_locks),
    .perm_lock(perm_lock)
  );

  // reference state, built from the requirements
  int m_mode, m_st;
  logic [7:0] m_err;
  logic [15:0] m_locks;
  bit m_perm, e_start;
  int e_op;
  logic [18:0] e_addr;
  logic [15:0] e_data;
  string m_tag;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_st = 0; m_err = 8'h00; m_locks = '0; m_perm = 0; e_start = 0;
  endtask

  function automatic logic [7:0] exp_status();
    return 8'h80 | m_err;
  endfunction

  task automatic model_apply(input logic [18:0] a, input logic [15:0] d, input bit h);
    logic [7:0] c = d[7:0];
    int blk = int'(a[18:15]);
    bit lk = m_locks[blk] && !h;
    e_start = 0; e_addr = a; e_data = d;
    if (m_st == 0) begin
      m_tag = "R2";
      case (c)
        8'hFF: m_mode = 0;
        8'h90: m_mode = 1;
        8'h70: m_mode = 2;
        8'h50: m_err = 8'h00;
        8'hB0: ;
        8'h20: begin m_st = 1; m_mode = 2; m_tag = "R5"; end
        8'h40, 8'h10: begin m_st = 2; m_mode = 2; m_tag = "R4"; end
        8'h60: begin m_st = 3; m_mode = 2; m_tag = "R7"; end
        default: begin m_err |= 8'h30; m_mode = 2; m_tag = "R6"; end
      endcase
    end else begin
      m_mode = 2;
      case (m_st)
        1: begin
          m_tag = "R5";
          if (c != 8'hD0) m_err |= 8'h30;
          else if (lk) begin m_err |= 8'h22; m_tag = "R9"; end
          else begin e_start = 1; e_op = 2; end
        end
        2: begin
          m_tag = "R4";
          if (lk) begin m_err |= 8'h12; m_tag = "R9"; end
          else begin e_start = 1; e_op = 1; end
        end
        default: begin
          m_tag = "R7";
          if (c == 8'h01) begin
            if (m_perm) begin m_err |= 8'h12; m_tag = "R8"; end
            else if (!h) m_err |= 8'h18;
            else begin m_locks[blk] = 1'b1; e_start = 1; e_op = 3; end
          end else if (c == 8'hF1) begin
            m_tag = "R8";
            if (!h) m_err |= 8'h18;
            else begin m_perm = 1; e_start = 1; e_op = 4; end
          end else if (c == 8'hD0) begin
            if (m_perm) begin m_err |= 8'h22; m_tag = "R8"; end
            else if (!h) m_err |= 8'h28;
            else begin m_locks = '0; e_start = 1; e_op = 5; end
          end else begin m_err |= 8'h30; m_tag = "R5"; end
        end
      endcase
      m_st = 0;
    end
  endtask

  // one bus cycle; we_n rises first, the design reacts at the next edge
  task automatic bus_write(input logic [18:0] a, input logic [15:0] d, input bit h,
                           input bit use_ce);
    @(negedge clk);
    addr = a; din = d; hv_reset = h; we_n = 1'b0; ce_n = !use_ce;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [18:0] a, input logic [15:0] d, input bit h,
                        input string tag);
    string t;
    bus_write(a, d, h, 1'b1);
    model_apply(a, d, h);
    t = (tag != "") ? tag : m_tag;
    chk({t, " mode"}, 32'(read_mode), 32'(m_mode));
    chk({t, " status"}, 32'(status), 32'(exp_status()));
    chk({t, " locks"}, {15'd0, perm_lock, block_locks}, {15'd0, m_perm, m_locks});
    chk({t, " start"}, 32'(wsm_start), 32'(e_start));
    if (e_start) begin
      chk({t, " op"}, 32'(wsm_op), 32'(e_op));
      chk({t, " addr/data"}, {wsm_addr[15:0], wsm_data}, {e_addr[15:0], e_data});
    end
    ce_n = 1'b1;
  endtask

  function automatic logic [18:0] baddr(input int blk, input int off);
    return {4'(blk), 15'(off)};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(read_mode), 0);
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 locks", {15'd0, perm_lock, block_locks}, 0);
    chk("R1 pulses", {wsm_start, wsm_suspend, wsm_resume}, 0);

    // R3 single strobe: chip enable stays high, nothing happens
    bus_write(baddr(0, 0), 16'h0070, 1'b0, 1'b0);
    chk("R3 ignored mode", 32'(read_mode), 0);
    chk("R3 ignored status", 32'(status), 32'h80);
    bus_write(baddr(0, 0), 16'h0020, 1'b0, 1'b0);
    do_cmd(baddr(0, 1), 16'h00D0, 0, "R3");   // erase setup was never seen -> error
    do_cmd(baddr(0, 0), 16'h0050, 0, "R2");
    do_cmd(baddr(0, 0), 16'h0070, 0, "R2");

    // R7 / R9 directed
    do_cmd(baddr(3, 0), 16'h0060, 0, "R7");
    do_cmd(baddr(3, 0), 16'h0001, 0, "R7");   // no high voltage
    do_cmd(baddr(3, 0), 16'h0050, 0, "R2");
    do_cmd(baddr(3, 0), 16'h0060, 1, "R7");
    do_cmd(baddr(3, 9), 16'hAB01, 1, "R7");   // set lock block 3
    do_cmd(baddr(3, 4), 16'h0020, 0, "R9");
    do_cmd(baddr(3, 4), 16'h00D0, 0, "R9");   // rejected
    do_cmd(baddr(3, 4), 16'h0040, 0, "R9");
    do_cmd(baddr(3, 4), 16'hBEEF, 0, "R9");   // rejected
    do_cmd(baddr(3, 5), 16'h0010, 1, "R9");
    do_cmd(baddr(3, 5), 16'h1234, 1, "R9");   // high voltage overrides
    do_cmd(baddr(1, 7), 16'h0020, 0, "R5");
    do_cmd(baddr(1, 7), 16'h00D0, 0, "R5");
    do_cmd(baddr(1, 7), 16'h0020, 0, "R5");
    do_cmd(baddr(1, 7), 16'h0055, 0, "R5");   // bad confirm
    do_cmd(baddr(0, 0), 16'h0060, 1, "R7");
    do_cmd(baddr(0, 0), 16'h00D0, 1, "R7");   // clear all
    do_cmd(baddr(0, 0), 16'h00FF, 0, "R12");
    do_cmd(baddr(0, 0), 16'h0090, 0, "R2");
    do_cmd(baddr(0, 0), 16'h0077, 0, "R6");
    do_cmd(baddr(0, 0), 16'h0050, 0, "R2");
    do_cmd(baddr(2, 3), 16'h0040, 0, "R4");
    do_cmd(baddr(2, 3), 16'h5AA5, 0, "R4");
    chk("R12 holds status mode", 32'(read_mode), 2);

    // random mix checked against the reference model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pool [13] = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'hD0, 8'h40,
                                8'h10, 8'h60, 8'h01, 8'hF1, 8'hB0, 8'h00};
      int k = int'($urandom % 13);
      logic [7:0] c = (k == 12) ? 8'($urandom) : pool[k];
      logic [15:0] d = {8'($urandom), c};
      do_cmd(baddr(int'($urandom % 4), int'($urandom % 32768)), d,
             bit'($urandom % 2), "");
    end

    // R8 permanent lock directed
    do_cmd(baddr(2, 0), 16'h0050, 0, "R2");
    do_cmd(baddr(2, 0), 16'h0060, 1, "R8");
    do_cmd(baddr(2, 0), 16'h00F1, 1, "R8");
    do_cmd(baddr(2, 0), 16'h0060, 1, "R8");
    do_cmd(baddr(2, 0), 16'h0001, 1, "R8");   // rejected, locks unchanged
    do_cmd(baddr(2, 0), 16'h0060, 1, "R8");
    do_cmd(baddr(2, 0), 16'h00D0, 1, "R8");   // rejected
    do_cmd(baddr(2, 0), 16'h0050, 0, "R8");
    do_cmd(baddr(2, 0), 16'h00FF, 0, "R8");
    chk("R8 perm kept", 32'(perm_lock), 1);

    // R10 / R11 busy and suspend
    wsm_busy = 1'b1;
    #1 chk("R10 ready low", 32'(status[7]), 0);
    bus_write(baddr(0, 0), 16'h00B0, 0, 1'b1);
    chk("R11 suspend pulse", {wsm_suspend, wsm_resume, wsm_start}, 3'b100);
    chk("R11 status", 32'(status), 32'h40);
    chk("R12 mode", 32'(read_mode), 2);
    ce_n = 1'b1;
    @(negedge clk);
    chk("R11 pulse width", 32'(wsm_suspend), 0);
    wsm_busy = 1'b0;
    #1 chk("R10 ready high", 32'(status), 32'hC0);
    bus_write(baddr(1, 0), 16'h0020, 0, 1'b1);
    chk("R11 setup ignored", {wsm_start, status}, {1'b0, 8'hC0});
    ce_n = 1'b1;
    bus_write(baddr(1, 0), 16'h00D0, 0, 1'b1);
    chk("R11 resume", {wsm_resume, wsm_start, status}, {2'b10, 8'h80});
    ce_n = 1'b1;
    wsm_busy = 1'b1;
    bus_write(baddr(1, 0), 16'h0040, 0, 1'b1);
    ce_n = 1'b1;
    bus_write(baddr(1, 0), 16'h1234, 0, 1'b1);
    chk("R11 busy ignores", {wsm_start, status}, {1'b0, 8'h00});
    ce_n = 1'b1;
    wsm_busy = 1'b0;
    #1 chk("R10 ready back", 32'(status), 32'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule